// File: doc/BRIEF.md
# Frame-Job Queue Controller

This block is the control and status front of a camera front-end pipeline. Software fills a shadow configuration window through a 32-bit register port, then writes a queue command. The queued job waits for the next start-of-frame strobe from the pixel datapath. On that strobe the whole shadow window is copied into the active configuration in one cycle, and the job becomes the frame in progress.

While a frame runs, the block counts the lines each output channel delivers and raises a line-threshold interrupt when a count reaches its programmed value. It also raises frame-start, frame-end, statistics-done and queue-ready interrupts. Status registers are read from a snapshot that software refreshes with a latch command, so a group of reads is coherent. Abort and reset commands bring the job state back to idle.

Top module: `fjq_ctrl`

## Requirements
- R1: A read of word 0x000 returns the revision word: major revision in bits 31:24, minor revision in bits 23:20, the other bits zero.
- R2: A CONTROL (0x004) write with bit 0 set, while no job is queued, marks a job queued. The STATUS word (0x008) then reads bit 0 (queued) = 1 and bit 1 (waiting) = 1, where waiting means queued with no frame in progress. The active configuration does not change before a start-of-frame strobe.
- R3: A start-of-frame strobe while a job is queued copies every shadow word (0x040 upward) into the active configuration. The same strobe clears queued, sets bit 2 (active), raises interrupt bit 24 (queue ready) and increments the frame count read at 0x00C.
- R4: Writes to the shadow window after a promotion leave the active configuration unchanged until the next promotion. The shadow words read back the written values.
- R5: A queue command while a job is already queued is ignored, so STATUS is unchanged. It sets bit 0 of the error word at 0x010.
- R6: Frame-end sets interrupt bit 0 and clears active. Frame-start sets interrupt bit 1. Statistics-done sets interrupt bit 16.
- R7: Each output i has a line threshold at 0x020+4*i. Its line counter counts line strobes only while a frame is active and clears on every frame-start. When the counter reaches a nonzero threshold, interrupt bit 8+i is set. The counters read packed at 0x014, output i in bits 16*i+15:16*i.
- R8: Writing to 0x01C clears each interrupt bit written as one and leaves the others pending.
- R9: The interrupt output is high one cycle after any bit is set in both the interrupt status and the enable word at 0x018, and low one cycle after no such bit remains.
- R10: A CONTROL write with bit 1 (abort) makes STATUS zero on the next cycle and keeps pending interrupts.
- R11: The reset input, and a CONTROL write with bit 2, clear the job state, the line counters, the frame count, the error word and the interrupt status.
- R12: Reads of 0x008 to 0x01C return the values captured at the last CONTROL write with bit 3 (latch), not the live values.
- R13: A start-of-frame strobe with no queued job promotes nothing. The active configuration is unchanged and bit 24 is not raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | ADDR_W-2 | Word address (byte address bits ADDR_W-1:2) |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rd | input | 1 | Register read strobe; data valid the next cycle |
| reg_rdata | output | 32 | Registered read data |
| sof | input | 1 | Start-of-frame strobe |
| eof | input | 1 | End-of-frame strobe |
| line_done | input | N_OUT | Per-output line-complete strobes |
| stats_done | input | 1 | Statistics-complete strobe |
| act_cfg | output | 32*CFG_WORDS | Active configuration, word w in bits 32*w+31:32*w |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench checks the shadow-to-active handoff: an early promotion would show new words in the active configuration before frame-start, and a missing one would leave stale words. It issues a duplicate queue command, which must leave the state alone and set the error flag; a design that accepts it would clear the job or lose it. It sends line strobes while no frame is active and just after a frame-start, where a counter that does not gate or clear would report wrong counts. It reads status without a fresh latch, which exposes live reads, and after an abort, which exposes a design that drops pending interrupts or leaves the job state set.

// File: rtl/fjq_pkg.sv
package fjq_pkg;
  // word indices of the register map (byte offset / 4)
  localparam int unsigned OFS_VER  = 0;
  localparam int unsigned OFS_CTRL = 1;
  localparam int unsigned OFS_STAT = 2;
  localparam int unsigned OFS_FRM  = 3;
  localparam int unsigned OFS_ERR  = 4;
  localparam int unsigned OFS_OUT  = 5;
  localparam int unsigned OFS_IEN  = 6;
  localparam int unsigned OFS_IST  = 7;
  localparam int unsigned OFS_THR0 = 8;
  localparam int unsigned OFS_CFG  = 16;

  // command bits in the control word
  localparam int unsigned CMD_QUEUE = 0;
  localparam int unsigned CMD_ABORT = 1;
  localparam int unsigned CMD_RESET = 2;
  localparam int unsigned CMD_LATCH = 3;

  // interrupt bit positions
  localparam int unsigned IB_EOF   = 0;
  localparam int unsigned IB_SOF   = 1;
  localparam int unsigned IB_LINE0 = 8;
  localparam int unsigned IB_STATS = 16;
  localparam int unsigned IB_QRDY  = 24;

  typedef struct packed {
    logic active;
    logic waiting;
    logic queued;
  } job_stat_t;
endpackage

// File: rtl/fjq_job_ctl.sv
module fjq_job_ctl #(
  parameter int FRM_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_queue,
  input  logic             cmd_abort,
  input  logic             cmd_reset,
  input  logic             sof,
  input  logic             eof,
  output logic             queued,
  output logic             active,
  output logic             promote,
  output logic             err_dup,
  output logic [FRM_W-1:0] frame_cnt
);
  logic kill;
  assign kill    = cmd_abort | cmd_reset;
  assign promote = sof & queued & ~kill;

  always_ff @(posedge clk) begin
    if (rst || cmd_reset) begin
      queued    <= 1'b0;
      active    <= 1'b0;
      err_dup   <= 1'b0;
      frame_cnt <= '0;
    end else if (cmd_abort) begin
      queued <= 1'b0;
      active <= 1'b0;
    end else begin
      if (promote) begin
        queued    <= 1'b0;
        active    <= 1'b1;
        frame_cnt <= frame_cnt + 1'b1;
      end else if (eof) begin
        active <= 1'b0;
      end
      if (cmd_queue) begin
        if (queued) err_dup <= 1'b1;
        else        queued  <= 1'b1;
      end
    end
  end

  AST_PROMOTE_GOES_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    promote |=> (active && !queued)); // R3
  AST_DUP_QUEUE_FLAGGED: assert property (@(posedge clk) disable iff (rst)
    (cmd_queue && queued && !kill) |=> (err_dup && queued)); // R5
  AST_ABORT_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
    cmd_abort |=> (!queued && !active)); // R10
  AST_RESET_CLEARS_JOB: assert property (@(posedge clk) disable iff (rst)
    cmd_reset |=> (!err_dup && frame_cnt == '0 && !queued)); // R11
endmodule

// File: rtl/fjq_line_cnt.sv
module fjq_line_cnt #(
  parameter int LINE_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              en,
  input  logic              line,
  input  logic [LINE_W-1:0] thr,
  output logic [LINE_W-1:0] cnt,
  output logic              hit
);
  logic [LINE_W-1:0] nxt;
  assign nxt = cnt + 1'b1;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
      hit <= 1'b0;
    end else begin
      hit <= 1'b0;
      if (en && line) begin
        cnt <= nxt;
        hit <= (nxt == thr) && (thr != '0);
      end
    end
  end

  AST_HIT_AT_THRESHOLD: assert property (@(posedge clk) disable iff (rst)
    hit |-> (cnt == $past(thr))); // R7
  AST_IDLE_NO_COUNT: assert property (@(posedge clk) disable iff (rst)
    (!en && !clr) |=> $stable(cnt)); // R7
endmodule

// File: rtl/fjq_ctrl.sv
module fjq_ctrl
  import fjq_pkg::*;
#(
  parameter int         CFG_WORDS = 8,
  parameter int         N_OUT     = 2,
  parameter int         LINE_W    = 16,
  parameter int         ADDR_W    = 8,
  parameter int         FRM_W     = 16,
  parameter logic [7:0] VER_MAJOR = 8'd3,
  parameter logic [3:0] VER_MINOR = 4'd1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [ADDR_W-1:2]       reg_addr,
  input  logic                    reg_wr,
  input  logic [31:0]             reg_wdata,
  input  logic                    reg_rd,
  output logic [31:0]             reg_rdata,
  input  logic                    sof,
  input  logic                    eof,
  input  logic [N_OUT-1:0]        line_done,
  input  logic                    stats_done,
  output logic [CFG_WORDS*32-1:0] act_cfg,
  output logic                    irq
);
  localparam int IDX_W = ADDR_W - 2;
  localparam int ACT_W = CFG_WORDS * 32;

  logic [IDX_W-1:0] widx;
  assign widx = reg_addr;

  // command decode
  logic ctrl_wr, cmd_queue, cmd_abort, cmd_reset, cmd_latch, ist_wr, ien_wr;
  assign ctrl_wr   = reg_wr && (widx == IDX_W'(OFS_CTRL));
  assign cmd_queue = ctrl_wr & reg_wdata[CMD_QUEUE];
  assign cmd_abort = ctrl_wr & reg_wdata[CMD_ABORT];
  assign cmd_reset = ctrl_wr & reg_wdata[CMD_RESET];
  assign cmd_latch = ctrl_wr & reg_wdata[CMD_LATCH];
  assign ist_wr    = reg_wr && (widx == IDX_W'(OFS_IST));
  assign ien_wr    = reg_wr && (widx == IDX_W'(OFS_IEN));

  // job state
  logic             queued, active, promote, err_dup;
  logic [FRM_W-1:0] frame_cnt;

  fjq_job_ctl #(.FRM_W(FRM_W)) u_job (
    .clk(clk), .rst(rst), .cmd_queue(cmd_queue), .cmd_abort(cmd_abort),
    .cmd_reset(cmd_reset), .sof(sof), .eof(eof), .queued(queued),
    .active(active), .promote(promote), .err_dup(err_dup),
    .frame_cnt(frame_cnt)
  );

  // shadow window, thresholds, enable word
  logic [31:0]       shadow [CFG_WORDS];
  logic [LINE_W-1:0] thr    [N_OUT];
  logic [31:0]       int_en;
  logic [ACT_W-1:0]  act_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int w = 0; w < CFG_WORDS; w++) shadow[w] <= '0;
      for (int i = 0; i < N_OUT; i++)     thr[i]    <= '0;
      int_en <= '0;
    end else begin
      for (int w = 0; w < CFG_WORDS; w++)
        if (reg_wr && widx == IDX_W'(OFS_CFG + w)) shadow[w] <= reg_wdata;
      for (int i = 0; i < N_OUT; i++)
        if (reg_wr && widx == IDX_W'(OFS_THR0 + i)) thr[i] <= reg_wdata[LINE_W-1:0];
      if (ien_wr) int_en <= reg_wdata;
    end
  end

  // whole-window handoff in one cycle
  always_ff @(posedge clk) begin
    if (rst) act_q <= '0;
    else if (promote)
      for (int w = 0; w < CFG_WORDS; w++) act_q[w*32 +: 32] <= shadow[w];
  end
  assign act_cfg = act_q;

  // per-output line counters
  logic [LINE_W-1:0] lcnt [N_OUT];
  logic [N_OUT-1:0]  lhit;
  logic              line_clr;
  assign line_clr = sof | cmd_abort | cmd_reset;

  for (genvar i = 0; i < N_OUT; i++) begin : g_line
    fjq_line_cnt #(.LINE_W(LINE_W)) u_lc (
      .clk(clk), .rst(rst), .clr(line_clr), .en(active),
      .line(line_done[i]), .thr(thr[i]), .cnt(lcnt[i]), .hit(lhit[i])
    );
  end

  // interrupt status, write-one-to-clear, sets win over clears
  logic [31:0] int_set, int_st;
  always_comb begin
    int_set           = '0;
    int_set[IB_EOF]   = eof;
    int_set[IB_SOF]   = sof;
    int_set[IB_STATS] = stats_done;
    int_set[IB_QRDY]  = promote;
    for (int i = 0; i < N_OUT; i++) int_set[IB_LINE0 + i] = lhit[i];
  end

  always_ff @(posedge clk) begin
    if (rst || cmd_reset) int_st <= '0;
    else int_st <= (int_st & ~(ist_wr ? reg_wdata : 32'd0)) | int_set;
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(int_st & int_en);
  end

  // snapshot of status on latch command
  job_stat_t   live_stat;
  logic [31:0] out_live;
  logic [31:0] snap_stat, snap_frm, snap_err, snap_out, snap_ist;
  assign live_stat = '{active: active, waiting: queued & ~active, queued: queued};

  always_comb begin
    out_live = '0;
    for (int i = 0; i < N_OUT; i++) out_live[i*LINE_W +: LINE_W] = lcnt[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      snap_stat <= '0; snap_frm <= '0; snap_err <= '0;
      snap_out  <= '0; snap_ist <= '0;
    end else if (cmd_latch) begin
      snap_stat <= 32'(live_stat);
      snap_frm  <= 32'(frame_cnt);
      snap_err  <= 32'(err_dup);
      snap_out  <= out_live;
      snap_ist  <= int_st;
    end
  end

  // read mux, registered
  logic [31:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    case (widx)
      IDX_W'(OFS_VER):  rd_mux = {VER_MAJOR, VER_MINOR, 20'd0};
      IDX_W'(OFS_STAT): rd_mux = snap_stat;
      IDX_W'(OFS_FRM):  rd_mux = snap_frm;
      IDX_W'(OFS_ERR):  rd_mux = snap_err;
      IDX_W'(OFS_OUT):  rd_mux = snap_out;
      IDX_W'(OFS_IEN):  rd_mux = int_en;
      IDX_W'(OFS_IST):  rd_mux = snap_ist;
      default:          rd_mux = '0;
    endcase
    for (int i = 0; i < N_OUT; i++)
      if (widx == IDX_W'(OFS_THR0 + i)) rd_mux = 32'(thr[i]);
    for (int w = 0; w < CFG_WORDS; w++)
      if (widx == IDX_W'(OFS_CFG + w)) rd_mux = shadow[w];
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end

  AST_QRDY_ON_PROMOTE: assert property (@(posedge clk) disable iff (rst)
    promote |=> int_st[IB_QRDY]); // R3
  AST_ACT_HELD: assert property (@(posedge clk) disable iff (rst)
    !promote |=> $stable(act_cfg)); // R4
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
    ist_wr |=> ((int_st & $past(reg_wdata) & ~$past(int_set)) == 32'd0)); // R8
  AST_IRQ_RISES: assert property (@(posedge clk) disable iff (rst)
    (|(int_st & int_en)) |=> irq); // R9
  AST_IRQ_FALLS: assert property (@(posedge clk) disable iff (rst)
    !(|(int_st & int_en)) |=> !irq); // R9
  AST_RESET_CMD_IST: assert property (@(posedge clk) disable iff (rst)
    cmd_reset |=> (int_st == 32'd0)); // R11
endmodule

// File: tb/sim_fjq_ctrl.sv
module sim_fjq_ctrl;
  localparam int CFG_WORDS = 8;
  localparam int N_OUT     = 2;

  logic                    clk = 1'b0;
  logic                    rst = 1'b1;
  logic [7:2]              reg_addr = '0;
  logic                    reg_wr = 1'b0;
  logic [31:0]             reg_wdata = '0;
  logic                    reg_rd = 1'b0;
  logic [31:0]             reg_rdata;
  logic                    sof = 1'b0, eof = 1'b0, stats_done = 1'b0;
  logic [N_OUT-1:0]        line_done = '0;
  logic [CFG_WORDS*32-1:0] act_cfg;
  logic                    irq;

  int n_chk  = 0;
  int n_fail = 0;
  logic [31:0] exp_q [$];
  string       tag_q [$];
  logic        rv_q = 1'b0;

  always #2 clk = ~clk;

  fjq_ctrl u0 (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .sof(sof), .eof(eof), .line_done(line_done), .stats_done(stats_done),
    .act_cfg(act_cfg), .irq(irq)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // monitor: pops an expected read result one cycle after each read
  always @(posedge clk) rv_q <= reg_rd;
  always @(negedge clk) begin
    if (rv_q) begin
      if (exp_q.size() == 0) check(reg_rdata, 32'hDEAD_BEEF, "unexpected read");
      else check(reg_rdata, exp_q.pop_front(), tag_q.pop_front());
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_addr = a[7:2]; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    reg_addr = a[7:2]; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic latch();
    wr(8'h04, 32'h8);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic pulse_sof();   sof = 1'b1;        @(negedge clk); sof = 1'b0;        endtask
  task automatic pulse_eof();   eof = 1'b1;        @(negedge clk); eof = 1'b0;        endtask
  task automatic pulse_stats(); stats_done = 1'b1; @(negedge clk); stats_done = 1'b0; endtask
  task automatic pulse_lines(input logic [N_OUT-1:0] m);
    line_done = m; @(negedge clk); line_done = '0;
  endtask

  function automatic logic [31:0] cfgv(input int w);
    return 32'hC0DE_0000 + 32'(w);
  endfunction

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    idle(4);
    rst = 1'b0;
    idle(1);
    // reset state
    check(32'(irq), 32'd0, "R11 reset irq");
    check(act_cfg[31:0], 32'd0, "R11 reset act_cfg");
    rd(8'h00, 32'h0310_0000, "R1 version");
    latch();
    rd(8'h08, 32'd0, "R11 idle status after reset");

    for (int w = 0; w < CFG_WORDS; w++) wr(8'(8'h40 + 4*w), cfgv(w));
    wr(8'h20, 32'd3);
    wr(8'h24, 32'd5);
    rd(8'h24, 32'd5, "R7 threshold readback");

    // queue and promotion
    wr(8'h04, 32'h1);
    latch();
    rd(8'h08, 32'h3, "R2 queued+waiting");
    check(act_cfg[31:0], 32'd0, "R2 no early promotion");
    pulse_sof();
    rd(8'h08, 32'h3, "R12 stale status without latch");
    latch();
    rd(8'h08, 32'h4, "R3 active after sof");
    rd(8'h1C, 32'h0100_0002, "R3 qready and sof pending");
    for (int w = 0; w < CFG_WORDS; w++)
      check(act_cfg[w*32 +: 32], cfgv(w), "R3 active word copied");

    // shadow write after promotion
    wr(8'h40, 32'h0000_FFFF);
    idle(1);
    check(act_cfg[31:0], cfgv(0), "R4 active unchanged by shadow write");
    rd(8'h40, 32'h0000_FFFF, "R4 shadow readback");

    // line thresholds
    pulse_lines(2'b11); pulse_lines(2'b11); pulse_lines(2'b11);
    idle(1);
    latch();
    rd(8'h1C, 32'h0100_0102, "R7 output0 threshold");
    rd(8'h14, 32'h0003_0003, "R7 line counts");
    pulse_lines(2'b11); pulse_lines(2'b11);
    idle(1);
    latch();
    rd(8'h1C, 32'h0100_0302, "R7 output1 threshold");
    rd(8'h14, 32'h0005_0005, "R7 line counts 5");

    // write-one-to-clear
    wr(8'h1C, 32'h0000_0102);
    latch();
    rd(8'h1C, 32'h0100_0200, "R8 partial clear");

    // interrupt line
    wr(8'h18, 32'h0000_0200);
    idle(1);
    check(32'(irq), 32'd1, "R9 irq raised");
    wr(8'h18, 32'h0000_0100);
    idle(1);
    check(32'(irq), 32'd0, "R9 irq dropped");

    // frame end and stats
    pulse_stats();
    pulse_eof();
    latch();
    rd(8'h08, 32'h0, "R6 eof clears active");
    rd(8'h1C, 32'h0101_0201, "R6 eof and stats pending");

    // start of frame with nothing queued
    wr(8'h1C, 32'hFFFF_FFFF);
    pulse_sof();
    pulse_lines(2'b01);
    latch();
    rd(8'h1C, 32'h0000_0002, "R13 no qready without job");
    rd(8'h14, 32'h0, "R7 counters cleared, idle lines ignored");
    check(act_cfg[31:0], cfgv(0), "R13 active unchanged");

    // duplicate queue
    wr(8'h04, 32'h1);
    wr(8'h04, 32'h1);
    latch();
    rd(8'h10, 32'h1, "R5 duplicate flagged");
    rd(8'h08, 32'h3, "R5 state unchanged");
    pulse_sof();
    check(act_cfg[31:0], 32'h0000_FFFF, "R3 new shadow promoted");
    latch();
    rd(8'h0C, 32'd2, "R3 frame count");

    // abort
    wr(8'h04, 32'h1);
    latch();
    rd(8'h08, 32'h5, "R2 queued while active, not waiting");
    wr(8'h04, 32'h2);
    latch();
    rd(8'h08, 32'h0, "R10 idle after abort");
    rd(8'h1C, 32'h0100_0002, "R10 pending kept");

    // reset command
    wr(8'h18, 32'h0000_0002);
    idle(1);
    check(32'(irq), 32'd1, "R9 irq on sof enable");
    wr(8'h04, 32'h4);
    idle(1);
    check(32'(irq), 32'd0, "R11 irq after reset cmd");
    latch();
    rd(8'h1C, 32'h0, "R11 int status cleared");
    rd(8'h10, 32'h0, "R11 error cleared");
    rd(8'h0C, 32'h0, "R11 frame count cleared");
    rd(8'h08, 32'h0, "R11 job state cleared");
    idle(2);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule